// File: doc/BRIEF.md
# Flash Toggle-Status Completion Poller

This block sits on the host side of a parallel flash device and decides whether a program or erase operation that the host has already launched has finished. After a start pulse it reads the device status byte over a request/valid read port, again and again, and keeps the toggle bit of each read. A status bit that keeps flipping between back-to-back reads means the device's internal algorithm is still running. A toggle bit that holds still means the operation is over. A second status bit, the limit flag, tells the host that the device has gone past its internal time budget.

A flipping toggle bit alone does not stop polling. When the limit flag is also high, the toggle may have stopped at the same moment the flag rose, so the poller makes one more pair of confirmation reads before it decides. If the toggle is still moving on that confirmation, the operation has failed. The poller then writes the reset command once on its command port, so that the device returns to array reads, and raises fail. A pair counter that can be switched off ends polling with a timeout when the limit flag never rises.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, busy, done, fail, timeout, rd_req and cmd_we are all low.
- R2: A start pulse while busy is low raises busy on the next cycle, clears done, fail and timeout, and begins a read request. A start pulse while busy is high has no effect on the sequence of reads or on the result.
- R3: Status reads are made in pairs. If bit 6 (the toggle bit) of the second read equals bit 6 of the first, done rises, busy falls and no command write occurs. All other data bits are ignored for this comparison.
- R4: If bit 6 differs within a pair and bit 5 (the limit flag) of the second read of that pair is 0, a fresh pair of reads follows.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 1, exactly two confirmation reads follow. If bit 6 is equal across them, the result is done.
- R6: If bit 6 still differs across the confirmation reads, cmd_we is high for exactly one cycle with cmd_data equal to RESET_CMD (default 0xF0), and fail rises on the cycle after that write.
- R7: With the pair limit enabled, after MAX_PAIRS consecutive pairs that differ with bit 5 low, timeout rises with no command write.
- R8: At most one of done, fail and timeout is high, none of them is high while busy, and they hold their values until the next accepted start.
- R9: rd_req stays high until a cycle with rd_valid, and each rd_valid cycle while rd_req is high counts as one read. rd_valid while rd_req is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse that begins a polling run |
| rd_req | output | 1 | Status read request, held until serviced |
| rd_valid | input | 1 | Read data valid, completes the pending request |
| rd_data | input | DATA_W | Status byte returned by the read |
| cmd_we | output | 1 | One-cycle command write strobe |
| cmd_data | output | DATA_W | Command value, RESET_CMD while cmd_we is high |
| busy | output | 1 | Polling run in progress |
| done | output | 1 | Operation finished successfully |
| fail | output | 1 | Operation failed and the reset command has been written |
| timeout | output | 1 | Pair limit reached without the limit flag |

## Verification
The assertions check the properties that hold on every cycle. Read requests occur only while busy, and a request stays up until it is serviced. The result flags are mutually exclusive, hold while idle and stay low during a run. Every command write carries the reset value, fail never rises without a write on the cycle before, and an idle start always raises busy. Only the bench scenarios can show that the decision is correct: that the right number of reads is made and the right result reached for a given toggle pattern and a given read on which the limit flag rises, that confirmation reads follow the limit flag, and that the timeout falls on the configured pair count. They also show that a second start during a run, and stray valid pulses while idle, leave the outcome untouched.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_A,
      S_RD_B,
      S_CF_A,
      S_CF_B,
      S_RST_WR
   } tpc_state_e;
endpackage

// File: rtl/tpc_bit_sampler.sv
module tpc_bit_sampler #(
   parameter int DATA_W     = 8,
   parameter int TOGGLE_BIT = 6,
   parameter int LIMIT_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] rd_data,
   output logic              toggled,
   output logic              limit_hi
);
   logic first_q;
   logic unused_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     first_q <= 1'b0;
      else if (load)  first_q <= rd_data[TOGGLE_BIT];
   end

   assign toggled     = first_q ^ rd_data[TOGGLE_BIT];
   assign limit_hi    = rd_data[LIMIT_BIT];
   assign unused_bits = ^rd_data;
endmodule

// File: rtl/tpc_pair_limit.sv
module tpc_pair_limit #(
   parameter int MAX_PAIRS = 1024,
   parameter bit USE_LIMIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic at_limit
);
   localparam int CW = $clog2(MAX_PAIRS + 1);

   generate
      if (USE_LIMIT) begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clear)  cnt_q <= '0;
            else if (bump)   cnt_q <= cnt_q + 1'b1;
         end
         assign at_limit = (cnt_q == CW'(MAX_PAIRS - 1));
      end else begin : g_nolimit
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clear, bump};
         assign at_limit  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
   parameter int              DATA_W     = 8,
   parameter int              TOGGLE_BIT = 6,
   parameter int              LIMIT_BIT  = 5,
   parameter int              MAX_PAIRS  = 1024,
   parameter bit              USE_LIMIT  = 1'b1,
   parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cmd_we,
   output logic [DATA_W-1:0] cmd_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              timeout
);
   import tpc_pkg::*;

   generate
      if (TOGGLE_BIT >= DATA_W || LIMIT_BIT >= DATA_W) begin : g_bad_bit
         $error("status bit index outside data width");
      end
      if (TOGGLE_BIT == LIMIT_BIT) begin : g_same_bit
         $error("toggle and limit bits must differ");
      end
      if (MAX_PAIRS < 1) begin : g_bad_pairs
         $error("MAX_PAIRS must be at least 1");
      end
   endgenerate

   tpc_state_e state_q;
   logic       busy_q, done_q, fail_q, tmo_q;
   logic       toggled, limit_hi, at_limit;
   logic       load_first, clear_cnt, bump_cnt, accept;

   assign accept     = (state_q == S_IDLE) && start;
   assign rd_req     = (state_q == S_RD_A) || (state_q == S_RD_B) ||
                       (state_q == S_CF_A) || (state_q == S_CF_B);
   assign load_first = rd_valid && ((state_q == S_RD_A) || (state_q == S_CF_A));
   assign clear_cnt  = accept;
   assign bump_cnt   = rd_valid && (state_q == S_RD_B) && toggled && !limit_hi;
   assign cmd_we     = (state_q == S_RST_WR);
   assign cmd_data   = cmd_we ? RESET_CMD : '0;

   tpc_bit_sampler #(
      .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .LIMIT_BIT(LIMIT_BIT)
   ) u_sample (
      .clk(clk), .rst_n(rst_n), .load(load_first), .rd_data(rd_data),
      .toggled(toggled), .limit_hi(limit_hi)
   );

   tpc_pair_limit #(
      .MAX_PAIRS(MAX_PAIRS), .USE_LIMIT(USE_LIMIT)
   ) u_limit (
      .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .bump(bump_cnt),
      .at_limit(at_limit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start) begin
               busy_q  <= 1'b1;
               done_q  <= 1'b0;
               fail_q  <= 1'b0;
               tmo_q   <= 1'b0;
               state_q <= S_RD_A;
            end
            S_RD_A: if (rd_valid) state_q <= S_RD_B;
            S_RD_B: if (rd_valid) begin
               if (!toggled) begin
                  done_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= S_IDLE;
               end else if (limit_hi) begin
                  state_q <= S_CF_A;
               end else if (at_limit) begin
                  tmo_q   <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= S_IDLE;
               end else begin
                  state_q <= S_RD_A;
               end
            end
            S_CF_A: if (rd_valid) state_q <= S_CF_B;
            S_CF_B: if (rd_valid) begin
               if (!toggled) begin
                  done_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= S_IDLE;
               end else begin
                  state_q <= S_RST_WR;
               end
            end
            S_RST_WR: begin
               fail_q  <= 1'b1;
               busy_q  <= 1'b0;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign fail    = fail_q;
   assign timeout = tmo_q;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rd_req,
   input logic              rd_valid,
   input logic              cmd_we,
   input logic [DATA_W-1:0] cmd_data,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              timeout
);
   p_req_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> rd_req);

   p_cmd_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |-> (cmd_data == RESET_CMD) && !rd_req && busy);

   p_fail_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(cmd_we));

   p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fail, timeout}));

   p_no_flag_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(done || fail || timeout));

   p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({done, fail, timeout}));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
endmodule

bind toggle_poll_ctrl tpc_checker #(
   .DATA_W(DATA_W), .RESET_CMD(RESET_CMD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
   .rd_valid(rd_valid), .cmd_we(cmd_we), .cmd_data(cmd_data),
   .busy(busy), .done(done), .fail(fail), .timeout(timeout)
);

// File: tb/sim_toggle_poll_ctrl.sv
module sim_toggle_poll_ctrl;
   localparam int MAXP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       rd_req;
   logic       rd_valid = 1'b0;
   logic [7:0] rd_data = 8'h00;
   logic       cmd_we;
   logic [7:0] cmd_data;
   logic       busy, done, fail, timeout;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_stop = 0;
   int d5_at = 999;
   int rd_idx = 0;
   int reads = 0;
   int cmd_cnt = 0;
   bit pend_fail = 1'b0;

   always #4 clk = ~clk;

   toggle_poll_ctrl #(.MAX_PAIRS(MAXP)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_we(cmd_we),
      .cmd_data(cmd_data), .busy(busy), .done(done), .fail(fail),
      .timeout(timeout)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit tog(input int k);
      return 1'(((k < n_stop) ? k : n_stop) & 1);
   endfunction

   // result: 1 done, 2 fail, 3 timeout
   function automatic void predict(output int res, output int nrd);
      int k = 0;
      int pairs = 0;
      res = 0;
      while (res == 0) begin
         bit a = tog(k);
         bit b = tog(k + 1);
         bit lim = (k + 1) >= d5_at;
         k += 2;
         if (a == b) res = 1;
         else if (lim) begin
            res = (tog(k) == tog(k + 1)) ? 1 : 2;
            k += 2;
         end else begin
            pairs++;
            if (pairs == MAXP) res = 3;
         end
      end
      nrd = k;
   endfunction

   // read responder
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req) begin
            logic [7:0] d;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            d = 8'($urandom);
            d[6] = tog(rd_idx);
            d[5] = (rd_idx >= d5_at);
            rd_data = d;
            rd_valid = 1'b1;
            rd_idx++;
            reads++;
            @(negedge clk);
            rd_valid = 1'b0;
         end
      end
   end

   // command write monitor
   always @(negedge clk) begin
      if (pend_fail) begin
         check(fail == 1'b1, "R6 fail after write", int'(fail), 1);
         pend_fail = 1'b0;
      end
      if (cmd_we) begin
         cmd_cnt++;
         check(cmd_data == 8'hF0, "R6 cmd value", int'(cmd_data), 8'hF0);
         check(fail == 1'b0, "R6 write before fail", int'(fail), 0);
         pend_fail = 1'b1;
      end
   end

   task automatic summary_and_end();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary_and_end();
      end
   end

   task automatic run(input int ns, input int d5, input bit poke, input string tag);
      int res, nrd, wait_c;
      n_stop = ns;
      d5_at = d5;
      rd_idx = 0;
      reads = 0;
      cmd_cnt = 0;
      predict(res, nrd);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      check(!(done || fail || timeout), "R2 flags cleared",
            int'({done, fail, timeout}), 0);
      wait_c = 0;
      while (busy && wait_c < 2000) begin
         @(negedge clk);
         wait_c++;
         if (poke && wait_c == 3) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      end
      @(negedge clk);
      check(done == (res == 1), {tag, " done"}, int'(done), int'(res == 1));
      check(fail == (res == 2), {tag, " fail"}, int'(fail), int'(res == 2));
      check(timeout == (res == 3), {tag, " timeout"}, int'(timeout), int'(res == 3));
      check(reads == nrd, {tag, " read count"}, reads, nrd);
      check(cmd_cnt == ((res == 2) ? 1 : 0), {tag, " cmd writes"}, cmd_cnt,
            (res == 2) ? 1 : 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check(!(busy || done || fail || timeout || rd_req || cmd_we), "R1 in reset",
            int'({busy, done, fail, timeout, rd_req, cmd_we}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!(busy || done || fail || timeout || rd_req || cmd_we), "R1 after reset",
            int'({busy, done, fail, timeout, rd_req, cmd_we}), 0);

      run(0, 999, 1'b0, "R3 stable first pair");
      run(3, 999, 1'b0, "R4 second pair settles");
      run(2, 1, 1'b0, "R5 confirm settles");
      run(50, 1, 1'b0, "R6 confirm still toggling");
      run(1000, 999, 1'b0, "R7 pair limit");
      run(5, 999, 1'b1, "R2 start while busy");
      run(40, 5, 1'b1, "R2 start while busy fail");

      // stray valid pulses while idle: R9
      begin
         logic [3:0] fl;
         fl = {busy, done, fail, timeout};
         repeat (3) begin
            @(negedge clk);
            rd_data = 8'($urandom);
            rd_valid = 1'b1;
            @(negedge clk);
            rd_valid = 1'b0;
         end
         @(negedge clk);
         check({busy, done, fail, timeout} == fl, "R9 stray valid ignored",
               int'({busy, done, fail, timeout}), int'(fl));
         check(rd_req == 1'b0, "R9 no request while idle", int'(rd_req), 0);
      end

      for (int i = 0; i < 25; i++) begin
         int ns = $urandom_range(0, 16);
         int d5 = ($urandom_range(0, 3) == 0) ? 999 : $urandom_range(0, 14);
         run(ns, d5, 1'b0, "R8 random run");
      end

      summary_and_end();
   end
endmodule